// File: doc/BRIEF.md
# IrDA SIR Transmit Framer

This block is the transmit side of a slow-rate infrared serial link. After a start strobe it sends a preamble, then the payload, then a closing flag. The preamble is a programmable run of 0xFF filler characters followed by one 0xC0 opening flag. The payload bytes arrive on a valid/ready stream. The closing flag is 0xC1. Every character is framed as ten bits: a start bit of 0, eight data bits sent LSB first, and a stop bit of 1. Every zero bit becomes a short light pulse at the start of its bit slot. A one bit leaves the output dark.

The pulse is 3/16 of a bit slot by default. A mode input selects a fixed pulse length instead, counted in system clocks. The block also drives the transceiver's shutdown/mode pin with inverted sense. It blanks the infrared receive path while a frame is being sent, and a separate disable input can keep that path blanked at all times.

Stream rules: a byte moves on the rising edge where `s_valid_i` and `s_ready_o` are both high. `s_ready_o` is high for one cycle, only at a character boundary in the payload phase. It never depends on `s_valid_i`. Holding `s_valid_i` low at that boundary ends the frame as an underrun. `s_last_i` marks the final byte.

Top module: `irsir_tx_framer`

## Requirements
- R1: A frame is sent in this order: the filler characters 0xFF, the opening flag 0xC0, the payload bytes, then the closing flag 0xC1. Each character has a 0 start bit, eight data bits LSB first and a 1 stop bit. Bit slots follow each other with no gap, and each slot is 16·max(`baud_div_i`,1) clocks long.
- R2: A preamble count c of 1 to 255 sends c−1 filler characters. A count of 0 sends 255 filler characters. The count is sampled at the start strobe.
- R3: Each zero bit produces exactly one pulse, and the pulse begins at the start of that bit's slot. One bits produce no pulse, and `ir_tx_o` is low at all other times.
- R4: With `pulse_fixed_i` = 0 (sampled at the start strobe), each pulse lasts 3·max(`baud_div_i`,1) clocks.
- R5: With `pulse_fixed_i` = 1, each pulse lasts FIX_CYC clocks. FIX_CYC must be shorter than one bit slot.
- R6: `sd_mode_o` is the inverse of `sd_ctrl_i`.
- R7: `ir_rx_o` follows `ir_rx_i` while the block is idle and `rx_dis_i` = 0. It is 0 whenever `busy_o` = 1 or `rx_dis_i` = 1.
- R8: Each payload byte is taken exactly once, on an edge where `s_valid_i` and `s_ready_o` are both high. `s_ready_o` is never high while the block is idle.
- R9: If `s_valid_i` is low at a payload boundary, the closing flag is sent in that slot and `underrun_o` pulses for exactly one cycle. No further bytes are taken.
- R10: A start strobe while `busy_o` = 1 has no effect. The frame is unchanged and no second frame follows.
- R11: After reset, `busy_o`, `ir_tx_o`, `s_ready_o` and `underrun_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start strobe, honoured only when idle |
| pre_count_i | input | 8 | Preamble count (0 means 256) |
| baud_div_i | input | DIV_W | Clocks per 1/16 bit slot (0 is treated as 1) |
| pulse_fixed_i | input | 1 | 0: 3/16-slot pulse, 1: FIX_CYC-clock pulse |
| sd_ctrl_i | input | 1 | Transceiver shutdown/mode control |
| rx_dis_i | input | 1 | Force the receive path off |
| s_valid_i | input | 1 | Payload byte valid |
| s_data_i | input | 8 | Payload byte |
| s_last_i | input | 1 | Marks the final payload byte |
| s_ready_o | output | 1 | Payload byte accepted this cycle |
| ir_tx_o | output | 1 | Infrared pulse output, active high |
| sd_mode_o | output | 1 | Transceiver shutdown/mode pin |
| ir_rx_i | input | 1 | Raw infrared receive input |
| ir_rx_o | output | 1 | Blanked infrared receive output |
| busy_o | output | 1 | Frame in progress |
| underrun_o | output | 1 | One-cycle payload underrun flag |

## Verification
Two functions can fall in the same cycle. The first is the underrun decision, which happens at a payload boundary. The second is dispatch of the closing flag, which uses that same slot. The bench provokes this by offering fewer bytes than needed and never asserting `s_last_i`. It judges the result by decoding the light pulses: 0xC1 must follow the last accepted byte with no gap, exactly one underrun cycle must be seen, and the transfer count must equal the bytes offered. A second overlap comes from starting a frame while the receive input is active. The bench checks that `ir_rx_o` is blanked in the first cycle `busy_o` is high.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  localparam logic [7:0] XBOF_CHAR = 8'hFF;
  localparam logic [7:0] BOF_CHAR  = 8'hC0;
  localparam logic [7:0] EOF_CHAR  = 8'hC1;
  localparam int SUBS_PER_BIT = 16;
  localparam int FRAC_SUBS    = 3;
  localparam int CHAR_BITS    = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_PAY, ST_EOF, ST_DRAIN
  } frm_state_e;
endpackage

// File: rtl/irsir_tick_gen.sv
module irsir_tick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (!run_i || cnt_q == lim) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irsir_char_ser.sv
module irsir_char_ser
  import irsir_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       nxt_valid_i,
  input  logic [7:0] nxt_char_i,
  output logic       take_o,
  output logic       active_o,
  output logic       zstart_o,
  output logic       bit_o,
  output logic [3:0] sub_o
);
  logic [CHAR_BITS-1:0] sh_q;
  logic [3:0]           bitn_q;
  logic [3:0]           sub_q;
  logic                 act_q;
  logic                 bit_end, last_bit;

  assign bit_end  = act_q && tick_i && (sub_q == 4'(SUBS_PER_BIT - 1));
  assign last_bit = (bitn_q == 4'(CHAR_BITS - 1));
  assign take_o   = nxt_valid_i && (!act_q || (bit_end && last_bit));
  // a zero bit begins: every load starts with the start bit
  assign zstart_o = take_o || (bit_end && !last_bit && !sh_q[1]);
  assign active_o = act_q;
  assign bit_o    = sh_q[0];
  assign sub_o    = sub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      bitn_q <= '0;
      sub_q  <= '0;
      act_q  <= 1'b0;
    end else if (take_o) begin
      sh_q   <= {1'b1, nxt_char_i, 1'b0};
      bitn_q <= '0;
      sub_q  <= '0;
      act_q  <= 1'b1;
    end else if (bit_end && last_bit) begin
      act_q  <= 1'b0;
      sh_q   <= '1;
    end else if (bit_end) begin
      sh_q   <= {1'b1, sh_q[CHAR_BITS-1:1]};
      bitn_q <= bitn_q + 1'b1;
      sub_q  <= '0;
    end else if (act_q && tick_i) begin
      sub_q  <= sub_q + 1'b1;
    end
  end

  // R1: a load from idle always opens with a zero start bit
  assert_start_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !act_q) |=> (act_q && !bit_o && sub_q == 4'd0));
endmodule

// File: rtl/irsir_pulse_shaper.sv
module irsir_pulse_shaper
  import irsir_pkg::*;
#(
  parameter int FIX_CYC = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fixed_i,
  input  logic       active_i,
  input  logic       bit_i,
  input  logic [3:0] sub_i,
  input  logic       zstart_i,
  output logic       pulse_o
);
  localparam int FW = $clog2(FIX_CYC + 1);
  logic [FW-1:0] cnt_q;
  logic          frac;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (zstart_i && fixed_i) cnt_q <= FW'(FIX_CYC);
    else if (cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
  end

  assign frac    = active_i && !bit_i && (sub_i < 4'(FRAC_SUBS));
  assign pulse_o = fixed_i ? (cnt_q != '0) : frac;

  // R3: every pulse begins right after a zero bit was started
  assert_pulse_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(zstart_i));
endmodule

// File: rtl/irsir_tx_framer.sv
module irsir_tx_framer
  import irsir_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int FIX_CYC = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [7:0]       pre_count_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             pulse_fixed_i,
  input  logic             sd_ctrl_i,
  input  logic             rx_dis_i,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_last_i,
  output logic             s_ready_o,
  output logic             ir_tx_o,
  output logic             sd_mode_o,
  input  logic             ir_rx_i,
  output logic             ir_rx_o,
  output logic             busy_o,
  output logic             underrun_o
);
  frm_state_e state_q;
  logic [8:0] rem_q;
  logic       mode_q;
  logic       urun_q;
  logic       nxt_valid;
  logic [7:0] nxt_char;
  logic       take, ser_active, zstart, cur_bit, tick;
  logic [3:0] sub;

  irsir_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(ser_active), .div_i(baud_div_i), .tick_o(tick));

  irsir_char_ser u_ser (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .nxt_valid_i(nxt_valid),
    .nxt_char_i(nxt_char), .take_o(take), .active_o(ser_active),
    .zstart_o(zstart), .bit_o(cur_bit), .sub_o(sub));

  irsir_pulse_shaper #(.FIX_CYC(FIX_CYC)) u_shape (
    .clk(clk), .rst_n(rst_n), .fixed_i(mode_q), .active_i(ser_active),
    .bit_i(cur_bit), .sub_i(sub), .zstart_i(zstart), .pulse_o(ir_tx_o));

  always_comb begin
    nxt_valid = 1'b0;
    nxt_char  = EOF_CHAR;
    case (state_q)
      ST_PRE: begin
        nxt_valid = 1'b1;
        nxt_char  = (rem_q == 9'd1) ? BOF_CHAR : XBOF_CHAR;
      end
      ST_PAY: begin
        nxt_valid = 1'b1;
        nxt_char  = s_valid_i ? s_data_i : EOF_CHAR;
      end
      ST_EOF:  nxt_valid = 1'b1;
      default: nxt_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      mode_q  <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      urun_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_PRE;
          rem_q   <= (pre_count_i == 8'd0) ? 9'd256 : {1'b0, pre_count_i};
          mode_q  <= pulse_fixed_i;
        end
        ST_PRE: if (take) begin
          rem_q <= rem_q - 9'd1;
          if (rem_q == 9'd1) state_q <= ST_PAY;
        end
        ST_PAY: if (take) begin
          if (!s_valid_i) begin
            urun_q  <= 1'b1;
            state_q <= ST_DRAIN;
          end else if (s_last_i) begin
            state_q <= ST_EOF;
          end
        end
        ST_EOF:   if (take) state_q <= ST_DRAIN;
        ST_DRAIN: if (!ser_active) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign s_ready_o  = (state_q == ST_PAY) && take;
  assign underrun_o = urun_q;
  assign sd_mode_o  = ~sd_ctrl_i;
  assign ir_rx_o    = ir_rx_i && !(busy_o || rx_dis_i);

  assert_underrun_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> !underrun_o);
  assert_ready_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> busy_o);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !ser_active);
  assert_rx_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !ir_rx_o);
endmodule

// File: tb/irsir_tx_framer_tb.sv
module irsir_tx_framer_tb_top;
  localparam int DIV_W = 12;
  localparam int FIX   = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, pfix = 1'b0, sdc = 1'b0, rxd = 1'b0, irrx = 1'b1;
  logic [7:0] prec = 8'd1;
  logic [DIV_W-1:0] div = 12'd2;
  logic sval, slast, srdy, irtx, sdm, irrxo, busy, urun;
  logic [7:0] sdat;

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, ne = 0, badw = 0, exp_w = 3, wcur = 0, ufl = 0, rdy_idle = 0, xfers = 0;
  int etimes[0:1023];
  logic [7:0] pl[0:15];
  logic [7:0] exp_c[0:299];
  int n_pl = 0, idx = 0;
  bit rec_en = 0, feed_en = 0, no_last = 0, ir_prev = 0;

  assign sval  = feed_en && (idx < n_pl);
  assign sdat  = (idx < n_pl) ? pl[idx] : 8'h00;
  assign slast = feed_en && (idx == n_pl - 1) && !no_last;

  irsir_tx_framer #(.DIV_W(DIV_W), .FIX_CYC(FIX)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pre_count_i(prec), .baud_div_i(div),
    .pulse_fixed_i(pfix), .sd_ctrl_i(sdc), .rx_dis_i(rxd), .s_valid_i(sval),
    .s_data_i(sdat), .s_last_i(slast), .s_ready_o(srdy), .ir_tx_o(irtx),
    .sd_mode_o(sdm), .ir_rx_i(irrx), .ir_rx_o(irrxo), .busy_o(busy), .underrun_o(urun));

  always @(posedge clk) if (sval && srdy) begin
    idx   <= idx + 1;
    xfers <= xfers + 1;
  end

  always @(negedge clk) begin
    cyc++;
    if (rec_en) begin
      if (irtx && !ir_prev) begin
        if (ne < 1024) etimes[ne] = cyc;
        ne++;
        wcur = 1;
      end else if (irtx) wcur++;
      else if (ir_prev && wcur != exp_w) badw++;
      if (urun) ufl++;
      if (srdy && !busy) rdy_idle++;
    end
    ir_prev = irtx;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic run_frame(input int pre, input int dv, input bit fx, input bit restart,
                           input int exp_ufl, input string tag);
    int nx, nc, i, mism, bp, t0, k, b, bv;
    nx = (pre == 0) ? 255 : pre - 1;
    nc = 0;
    for (int j = 0; j < nx; j++) begin exp_c[nc] = 8'hFF; nc++; end
    exp_c[nc] = 8'hC0; nc++;
    for (int j = 0; j < n_pl; j++) begin exp_c[nc] = pl[j]; nc++; end
    exp_c[nc] = 8'hC1; nc++;
    bp = 16 * ((dv == 0) ? 1 : dv);
    @(negedge clk);
    prec = 8'(pre); div = DIV_W'(dv); pfix = fx;
    exp_w = fx ? FIX : 3 * ((dv == 0) ? 1 : dv);
    ne = 0; badw = 0; ufl = 0; rdy_idle = 0; xfers = 0; idx = 0;
    rec_en = 1; feed_en = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R7: receive path blanked in the first busy cycle
    chk(busy && !irrxo, "R7", {tag, " rx blank at start"}, int'(irrxo), 0);
    if (restart) begin
      repeat (200) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (!busy);
    repeat (100) @(negedge clk);
    rec_en = 0; feed_en = 0;
    mism = 0; i = 0; t0 = etimes[0];
    for (k = 0; k < nc; k++)
      for (b = 0; b < 10; b++) begin
        bv = (b == 0) ? 0 : (b == 9) ? 1 : int'(exp_c[k][b-1]);
        if (bv == 0) begin
          if (i >= ne || i >= 1024 || etimes[i] != t0 + (k * 10 + b) * bp) mism++;
          i++;
        end
      end
    chk(mism == 0, (pre == 0 || pre > 1) ? "R2" : "R1", {tag, " pulse positions"}, mism, 0);
    chk(ne == i, "R3", {tag, " pulse count"}, ne, i);
    chk(badw == 0, fx ? "R5" : "R4", {tag, " pulse width mismatches"}, badw, 0);
    chk(ufl == exp_ufl, "R9", {tag, " underrun cycles"}, ufl, exp_ufl);
    chk(xfers == n_pl && rdy_idle == 0, "R8", {tag, " bytes taken"}, xfers, n_pl);
    if (restart) chk(!busy, "R10", {tag, " no second frame"}, int'(busy), 0);
  endtask

  task automatic test_reset();
    chk(!busy, "R11", "busy after reset", int'(busy), 0);
    chk(!irtx, "R11", "ir_tx after reset", int'(irtx), 0);
    chk(!srdy, "R11", "ready after reset", int'(srdy), 0);
    chk(!urun, "R11", "underrun after reset", int'(urun), 0);
  endtask

  task automatic test_pins();
    @(negedge clk); sdc = 1'b0; rxd = 1'b0; irrx = 1'b1;
    @(negedge clk);
    chk(sdm == 1'b1, "R6", "sd pin with ctrl 0", int'(sdm), 1);
    chk(irrxo == 1'b1, "R7", "rx passes when idle", int'(irrxo), 1);
    sdc = 1'b1; rxd = 1'b1;
    @(negedge clk);
    chk(sdm == 1'b0, "R6", "sd pin with ctrl 1", int'(sdm), 0);
    chk(irrxo == 1'b0, "R7", "rx forced off", int'(irrxo), 1'b0);
    rxd = 1'b0;
  endtask

  task automatic test_basic();
    pl[0] = 8'h55; pl[1] = 8'h00; pl[2] = 8'hA3; n_pl = 3; no_last = 0;
    run_frame(1, 2, 1'b0, 1'b0, 0, "basic R1");
  endtask

  task automatic test_fixed();
    pl[0] = 8'h7E; n_pl = 1; no_last = 0;
    run_frame(4, 3, 1'b1, 1'b0, 0, "fixed R5");
  endtask

  task automatic test_max_pre();
    pl[0] = 8'h12; n_pl = 1; no_last = 0;
    run_frame(0, 1, 1'b0, 1'b0, 0, "count0 R2");
  endtask

  task automatic test_underrun();
    pl[0] = 8'h11; pl[1] = 8'h22; n_pl = 2; no_last = 1;
    run_frame(2, 2, 1'b0, 1'b0, 1, "underrun R9");
    no_last = 0;
  endtask

  task automatic test_restart();
    pl[0] = 8'h3C; n_pl = 1; no_last = 0;
    run_frame(1, 2, 1'b0, 1'b1, 0, "restart R10");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_pins();
    test_basic();
    test_fixed();
    test_underrun();
    test_restart();
    test_max_pre();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule